// File: doc/BRIEF.md
# Word Multiply/Divide Execution Unit

This unit is the 32-bit "word" arithmetic slice of a 64-bit integer core. It decodes an instruction word and runs one of five operations on the low halves of two 64-bit register operands: multiply, signed divide, unsigned divide, signed remainder and unsigned remainder. The 32-bit result always comes back sign-extended to 64 bits, for the unsigned forms too.

A one-cycle start pulse hands over the instruction and both operands. The unit then returns a one-cycle done strobe. With that strobe it presents the result, the destination register index and a write enable.

Multiply finishes in a single cycle. Division uses a restoring loop that produces one quotient bit per clock. Divide-by-zero and signed overflow do not trap: each gets a fixed result that completes in a single cycle. An instruction that matches none of the five encodings completes at once with an illegal flag and no write.

Top module: `wmd_unit`

## Requirements
- R1: An instruction is accepted only when bits [31:25] equal 0000001 and bits [6:0] equal 0111011. Bits [14:12] then select the operation: 000 multiply, 100 signed divide, 101 unsigned divide, 110 signed remainder, 111 unsigned remainder. Bits [11:7] give the destination index. Any other instruction completes with `illegalOut` high, `wrEnOut` low and a result of zero.
- R2: Only bits [31:0] of each operand take part. The 32-bit result is sign-extended to 64 bits for every operation, the unsigned ones included.
- R3: Multiply returns the low 32 bits of the product of the two 32-bit operands.
- R4: Signed divide truncates toward zero. Signed remainder takes the sign of the dividend, so that dividend = quotient × divisor + remainder.
- R5: Unsigned divide and remainder treat both 32-bit operands as unsigned.
- R6: When the 32-bit divisor is zero, both divide forms return all ones. Both remainder forms return the 32-bit dividend, sign-extended.
- R7: Signed divide of -2^31 by -1 returns 0xFFFFFFFF80000000. Signed remainder returns 0 for the same pair.
- R8: A destination index of 0 keeps `wrEnOut` low. The operation still completes with a done strobe.
- R9: Take k as the rising edge that samples an accepted start. Multiply, illegal, zero-divisor and signed-overflow cases raise done at edge k. Every other division raises done at edge k+33.
- R10: `busyOut` is high from edge k until the edge that raises done. A start seen while `busyOut` is high is ignored and produces no result.
- R11: Each accepted start produces exactly one done strobe, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start pulse, taken when the unit is idle |
| instrIn | input | 32 | Instruction word |
| opA | input | 64 | First source operand (dividend / multiplicand) |
| opB | input | 64 | Second source operand (divisor / multiplier) |
| busyOut | output | 1 | An iterative division is in progress |
| doneOut | output | 1 | One-cycle completion strobe |
| resultOut | output | 64 | Sign-extended result, valid with done |
| rdOut | output | 5 | Destination index, valid with done |
| wrEnOut | output | 1 | Register write request, valid with done |
| illegalOut | output | 1 | Instruction not recognised, valid with done |

## Verification
Several properties are checked by assertions on every cycle:
- every completed result has its upper half equal to bit 31 of the result;
- an index of zero or an illegal flag never comes with a write;
- done never coincides with busy;
- the loop runs exactly 32 steps, and a start seen mid-loop leaves it running;
- the partial remainder stays below the divisor.

Arithmetic correctness cannot be checked that way. The bench's scenarios compare every result, index, flag and completion cycle against an independent model, over directed corner cases and random operands. Those cases include:
- zero divisors;
- the -2^31 / -1 pair;
- dirty upper operand halves;
- destination 0;
- a start injected while busy.

// File: rtl/wmd_pkg.sv
package wmd_pkg;

  localparam logic [6:0] MAJOR_CODE = 7'b0111011;
  localparam logic [6:0] GROUP_CODE = 7'b0000001;

  typedef enum logic [2:0] {
    OP_MUL,
    OP_DIV,
    OP_DIVU,
    OP_REM,
    OP_REMU,
    OP_BAD
  } wmdOp_e;

  typedef struct packed {
    logic loadFast;
    logic loadIter;
    logic step;
    logic finish;
  } wmdStrobe_t;

  function automatic wmdOp_e decodeOp(input logic [31:0] instr);
    wmdOp_e op;
    op = OP_BAD;
    if (instr[31:25] == GROUP_CODE && instr[6:0] == MAJOR_CODE) begin
      case (instr[14:12])
        3'b000:  op = OP_MUL;
        3'b100:  op = OP_DIV;
        3'b101:  op = OP_DIVU;
        3'b110:  op = OP_REM;
        3'b111:  op = OP_REMU;
        default: op = OP_BAD;
      endcase
    end
    return op;
  endfunction

endpackage

// File: rtl/wmd_ctrl.sv
module wmd_ctrl
  import wmd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       isFast,
  output wmdStrobe_t strobes,
  output logic       busyOut,
  output logic       doneOut
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ITER, ST_FIN} ctrlState_e;

  ctrlState_e state;
  logic [CNT_W-1:0] cnt;
  logic accept;

  assign accept  = startIn && (state == ST_IDLE);
  assign busyOut = (state != ST_IDLE);

  always_comb begin
    strobes.loadFast = accept && isFast;
    strobes.loadIter = accept && !isFast;
    strobes.step     = (state == ST_ITER);
    strobes.finish   = (state == ST_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (isFast) begin
              doneOut <= 1'b1;
            end else begin
              state <= ST_ITER;
              cnt   <= '0;
            end
          end
        end
        ST_ITER: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIN;
        end
        ST_FIN: begin
          doneOut <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_LOOP_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ITER && cnt == LAST) |=> (state == ST_FIN)); // R9
  AST_LOOP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadIter |=> (state == ST_ITER && cnt == '0)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && state == ST_ITER && cnt != LAST) |=> (state == ST_ITER && !doneOut)); // R10

endmodule

// File: rtl/wmd_dpath.sv
module wmd_dpath
  import wmd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       instrIn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  wmdStrobe_t        strobes,
  output logic              isFast,
  output logic [DATA_W-1:0] resultOut,
  output logic [4:0]        rdOut,
  output logic              wrEnOut,
  output logic              illegalOut
);

  localparam int EXT_W = DATA_W - WORD_W;
  localparam logic [WORD_W-1:0] MIN_NEG = {1'b1, {(WORD_W-1){1'b0}}};

  wmdOp_e op;
  logic [WORD_W-1:0] aw, bw, magA, magB, fastRes, finalRes;
  logic divZero, sOvf, signedOp, remOp, aNeg, bNeg;
  logic [4:0] rdField;
  logic unusedBits;

  logic [WORD_W-1:0] quoReg, remReg, divReg;
  logic negQ, negR, wantRem;
  logic [WORD_W:0] shifted, trial;
  logic fits;

  assign op       = decodeOp(instrIn);
  assign aw       = opA[WORD_W-1:0];
  assign bw       = opB[WORD_W-1:0];
  assign rdField  = instrIn[11:7];
  assign unusedBits = ^{opA[DATA_W-1:WORD_W], opB[DATA_W-1:WORD_W], instrIn[24:15]};
  assign divZero  = (bw == '0);
  assign signedOp = (op == OP_DIV) || (op == OP_REM);
  assign remOp    = (op == OP_REM) || (op == OP_REMU);
  assign sOvf     = signedOp && (aw == MIN_NEG) && (bw == '1);
  assign aNeg     = signedOp && aw[WORD_W-1];
  assign bNeg     = signedOp && bw[WORD_W-1];
  assign magA     = aNeg ? (~aw + 1'b1) : aw;
  assign magB     = bNeg ? (~bw + 1'b1) : bw;
  assign isFast   = (op == OP_MUL) || (op == OP_BAD) || divZero || sOvf;

  always_comb begin
    case (op)
      OP_MUL:          fastRes = aw * bw;
      OP_DIV, OP_DIVU: fastRes = divZero ? '1 : MIN_NEG;
      OP_REM, OP_REMU: fastRes = divZero ? aw : '0;
      default:         fastRes = '0;
    endcase
  end

  // restoring step: shift in next dividend bit, subtract if it fits
  assign shifted = {remReg, quoReg[WORD_W-1]};
  assign fits    = (shifted >= {1'b0, divReg});
  assign trial   = shifted - {1'b0, divReg};

  always_comb begin
    if (wantRem) finalRes = negR ? (~remReg + 1'b1) : remReg;
    else         finalRes = negQ ? (~quoReg + 1'b1) : quoReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quoReg     <= '0;
      remReg     <= '0;
      divReg     <= '0;
      negQ       <= 1'b0;
      negR       <= 1'b0;
      wantRem    <= 1'b0;
      resultOut  <= '0;
      rdOut      <= '0;
      wrEnOut    <= 1'b0;
      illegalOut <= 1'b0;
    end else begin
      if (strobes.loadFast) begin
        resultOut  <= {{EXT_W{fastRes[WORD_W-1]}}, fastRes};
        rdOut      <= rdField;
        wrEnOut    <= (op != OP_BAD) && (rdField != 5'd0);
        illegalOut <= (op == OP_BAD);
      end
      if (strobes.loadIter) begin
        quoReg     <= magA;
        remReg     <= '0;
        divReg     <= magB;
        negQ       <= aNeg ^ bNeg;
        negR       <= aNeg;
        wantRem    <= remOp;
        rdOut      <= rdField;
        wrEnOut    <= (rdField != 5'd0);
        illegalOut <= 1'b0;
      end
      if (strobes.step) begin
        remReg <= fits ? trial[WORD_W-1:0] : shifted[WORD_W-1:0];
        quoReg <= {quoReg[WORD_W-2:0], fits};
      end
      if (strobes.finish) begin
        resultOut <= {{EXT_W{finalRes[WORD_W-1]}}, finalRes};
      end
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |-> (remReg < divReg)); // R5
  AST_ITER_NONZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadIter |=> (divReg != '0)); // R6

endmodule

// File: rtl/wmd_unit.sv
module wmd_unit
  import wmd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [31:0]       instrIn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              busyOut,
  output logic              doneOut,
  output logic [DATA_W-1:0] resultOut,
  output logic [4:0]        rdOut,
  output logic              wrEnOut,
  output logic              illegalOut
);

  wmdStrobe_t strobes;
  logic isFast;

  wmd_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .isFast  (isFast),
    .strobes (strobes),
    .busyOut (busyOut),
    .doneOut (doneOut)
  );

  wmd_dpath #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .instrIn    (instrIn),
    .opA        (opA),
    .opB        (opB),
    .strobes    (strobes),
    .isFast     (isFast),
    .resultOut  (resultOut),
    .rdOut      (rdOut),
    .wrEnOut    (wrEnOut),
    .illegalOut (illegalOut)
  );

  AST_SIGN_EXTENDED: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (resultOut[DATA_W-1:WORD_W] == {(DATA_W-WORD_W){resultOut[WORD_W-1]}})); // R2
  AST_RD0_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && rdOut == 5'd0) |-> !wrEnOut); // R8
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && illegalOut) |-> (!wrEnOut && resultOut == '0)); // R1
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !busyOut); // R11
  AST_BUSY_HOLDS_RD: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && startIn) |=> $stable(rdOut)); // R10

endmodule

// File: tb/test_wmd_unit.sv
module test_wmd_unit;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] result;
    logic [4:0]  rd;
    logic        wrEn;
    logic        illegal;
    int          doneCyc;
    string       tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [31:0] instrIn = '0;
  logic [63:0] opA = '0, opB = '0;
  logic busyOut, doneOut, wrEnOut, illegalOut;
  logic [63:0] resultOut;
  logic [4:0] rdOut;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wmd_unit i_wmd_unit (
    .clk(clk), .rstN(rstN), .startIn(startIn), .instrIn(instrIn),
    .opA(opA), .opB(opB), .busyOut(busyOut), .doneOut(doneOut),
    .resultOut(resultOut), .rdOut(rdOut), .wrEnOut(wrEnOut), .illegalOut(illegalOut)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] f3, input logic [4:0] rd);
    return {7'b0000001, 5'd2, 5'd1, f3, rd, 7'b0111011};
  endfunction

  // independent model of the requirements
  function automatic expItem_t model(input logic [31:0] ins, input logic [63:0] a,
                                     input logic [63:0] b, input string tag);
    expItem_t e;
    int sa, sb;
    int unsigned ua, ub;
    logic [31:0] r;
    bit fast, legal;
    ua = a[31:0]; ub = b[31:0]; sa = a[31:0]; sb = b[31:0];
    legal = (ins[31:25] == 7'b0000001) && (ins[6:0] == 7'b0111011) &&
            (ins[14:12] == 3'b000 || ins[14:12][2]);
    r = '0; fast = 1'b1;
    if (legal) begin
      case (ins[14:12])
        3'b000: r = ua * ub;
        3'b100: if (ub == 0) r = '1;
                else if (ua == 32'h8000_0000 && ub == 32'hFFFF_FFFF) r = 32'h8000_0000;
                else begin r = sa / sb; fast = 1'b0; end
        3'b101: if (ub == 0) r = '1; else begin r = ua / ub; fast = 1'b0; end
        3'b110: if (ub == 0) r = ua;
                else if (ua == 32'h8000_0000 && ub == 32'hFFFF_FFFF) r = '0;
                else begin r = sa % sb; fast = 1'b0; end
        default: if (ub == 0) r = ua; else begin r = ua % ub; fast = 1'b0; end
      endcase
    end
    e.result  = {{32{r[31]}}, r};
    e.rd      = ins[11:7];
    e.illegal = !legal;
    e.wrEn    = legal && (ins[11:7] != 5'd0);
    e.doneCyc = cyc + 1 + (fast ? 0 : 33);
    e.tag     = tag;
    return e;
  endfunction

  // driver: called at a negedge, returns at a negedge with start low
  task automatic issue(input logic [31:0] ins, input logic [63:0] a,
                       input logic [63:0] b, input string tag);
    while (busyOut) @(negedge clk);
    instrIn = ins; opA = a; opB = b; startIn = 1'b1;
    expQ.push_back(model(ins, a, b, tag));
    @(negedge clk);
    startIn = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && doneOut) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11", "unexpected done", 64'd1, 64'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(resultOut == e.result, e.tag, "result", resultOut, e.result);
        check(rdOut == e.rd, e.tag, "rd", 64'(rdOut), 64'(e.rd));
        check(wrEnOut == e.wrEn, e.tag, "wrEn", 64'(wrEnOut), 64'(e.wrEn));
        check(illegalOut == e.illegal, e.tag, "illegal", 64'(illegalOut), 64'(e.illegal));
        check(cyc == e.doneCyc, {e.tag, " R9"}, "done cycle", 64'(cyc), 64'(e.doneCyc));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", "timeout", 64'(cyc), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!doneOut && !busyOut && !wrEnOut, "reset", "done/busy/wrEn",
          {61'd0, doneOut, busyOut, wrEnOut}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(resultOut == 64'd0, "reset", "result", resultOut, 64'd0);

    // R3 / R2: multiply with dirty upper halves, negative, wraparound
    issue(mk(3'b000, 5'd5), 64'hFFFF_FFFF_0000_0003, 64'h1234_5678_0000_0005, "R3 R2 mul dirty");
    issue(mk(3'b000, 5'd6), 64'h0000_0000_FFFF_FFFD, 64'd7, "R3 mul neg");
    issue(mk(3'b000, 5'd7), 64'h0000_0000_8000_0000, 64'd2, "R3 mul wrap");
    // R4 signed
    issue(mk(3'b100, 5'd8), 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, "R4 div 7/-2");
    issue(mk(3'b110, 5'd9), 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, "R4 rem 7%-2");
    issue(mk(3'b110, 5'd10), 64'hAAAA_AAAA_FFFF_FFF9, 64'd2, "R4 R2 rem -7%2");
    issue(mk(3'b100, 5'd11), 64'hFFFF_FFFF_8000_0000, 64'd3, "R4 div min/3");
    // R5 unsigned
    issue(mk(3'b101, 5'd12), 64'h0000_0000_FFFF_FFFF, 64'd1, "R5 R2 divu sext");
    issue(mk(3'b111, 5'd13), 64'd100, 64'd7, "R5 remu");
    issue(mk(3'b101, 5'd14), 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R5 divu min/-1");
    // R6 zero divisor (upper half of divisor nonzero)
    issue(mk(3'b100, 5'd15), 64'h1234_5678_8765_4321, 64'hABCD_0000_0000_0000, "R6 div zero");
    issue(mk(3'b101, 5'd16), 64'h1234_5678_8765_4321, 64'hABCD_0000_0000_0000, "R6 divu zero");
    issue(mk(3'b110, 5'd17), 64'h1234_5678_8765_4321, 64'hABCD_0000_0000_0000, "R6 rem zero");
    issue(mk(3'b111, 5'd18), 64'h1234_5678_1765_4321, 64'd0, "R6 remu zero");
    // R7 overflow
    issue(mk(3'b100, 5'd19), 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R7 div ovf");
    issue(mk(3'b110, 5'd20), 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R7 rem ovf");
    // R8 destination zero
    issue(mk(3'b100, 5'd0), 64'd50, 64'd5, "R8 div rd0");
    issue(mk(3'b000, 5'd0), 64'd50, 64'd5, "R8 mul rd0");
    // R1 illegal encodings
    issue(mk(3'b001, 5'd3), 64'd4, 64'd5, "R1 bad funct3");
    issue({7'b0000000, mk(3'b100, 5'd3)}[31:0] & 32'h01FF_FFFF, 64'd4, 64'd5, "R1 bad group");
    issue(mk(3'b000, 5'd4) ^ 32'h0000_0020, 64'd4, 64'd5, "R1 bad major");

    // R10: start during busy is ignored
    issue(mk(3'b101, 5'd21), 64'd1000, 64'd9, "R10 div before ignore");
    repeat (4) @(negedge clk);
    check(busyOut == 1'b1, "R10", "busy during loop", 64'(busyOut), 64'd1);
    instrIn = mk(3'b000, 5'd22); opA = 64'd3; opB = 64'd3; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    issue(mk(3'b000, 5'd23), 64'd6, 64'd7, "R10 after ignore");

    // random mix
    for (int i = 0; i < 150; i++) begin
      logic [2:0] f3;
      logic [63:0] a, b;
      case ($urandom_range(0, 4))
        0: f3 = 3'b000; 1: f3 = 3'b100; 2: f3 = 3'b101; 3: f3 = 3'b110; default: f3 = 3'b111;
      endcase
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) b[31:0] = 32'($urandom_range(0, 20)) - 32'd10;
      issue(mk(f3, 5'($urandom_range(0, 31))), a, b, "R2 R3 R4 R5 random");
    end

    repeat (40) @(negedge clk);
    check(expQ.size() == 0, "R11", "pending results", 64'(expQ.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule